// File: doc/BRIEF.md
# Interrupt Acceptance and Entry Sequencer

This block sits beside the execute stage of a 32-bit processor. While idle it watches three request sources: a normal interrupt (with a vector number and a priority level), a fast interrupt, and a synchronous exception (with a 9-bit vector). It compares them against the live status word. When a request is taken, the block captures everything it needs and then runs a fixed entry sequence. The sequence swaps the stack pointers, rewrites the status word, pushes state through a 32-bit memory port with a valid/ready handshake, and fetches the new program counter from a vector table. It then commits the new program counter and stack pointers in a single cycle and acknowledges the interrupt source.

A fast interrupt does not touch memory. It writes the old status word and program counter into backup registers and takes its target from a dedicated fast-vector register. States: `S_IDLE` (wait and decide), `S_SWAP` (stack swap and status update), `S_PUSH_SW`, `S_PUSH_PC`, `S_FETCH` (memory phase), `S_FSAVE` (fast backup) and `S_FINISH` (commit and acknowledge). Transitions:
- `S_IDLE` to `S_SWAP` on acceptance.
- `S_SWAP` to `S_PUSH_SW` for normal interrupts and exceptions, or to `S_FSAVE` for fast interrupts.
- Each memory state advances only on `mem_ready`: `S_PUSH_SW` to `S_PUSH_PC` to `S_FETCH` to `S_FINISH`.
- `S_FSAVE` to `S_FINISH`.
- `S_FINISH` to `S_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: A normal request is taken only when status bit 4 (enable) is 1 and the status level in bits 3:0 is strictly less than `nirq_lvl`.
- R2: A fast request is taken only when the enable bit is 1 and the status level is not 15.
- R3: An exception is taken regardless of enable and level. Priority is exception, then fast, then normal. `busy` rises one cycle after the accepting edge.
- R4: The vector, level, status word, program counter and stack values are captured on acceptance. Later changes on the inputs do not alter the entry.
- R5: The stack base is `isp_in` when status bit 5 (user-stack) is 1, otherwise `sp_in`. When bit 5 is 1, `usp_we` pulses once with `usp_out = sp_in`.
- R6: `sw_we` pulses once with `sw_out` equal to the captured word with bits 4, 5 and 6 (mode) cleared. For a normal interrupt, bits 3:0 are replaced by the accepted level; otherwise they are kept.
- R7: For normal interrupts and exceptions, exactly two stores occur in order: the status word to base-4, then the program counter to base-8.
- R8: A normal interrupt fetches its target from `tbase_in + vector*4`.
- R9: An exception with vector bit 8 set (a trap) fetches from `tbase_in + vector[7:0]*4`. Any other exception fetches from `0xFFFFFFC0 + vector*4`.
- R10: A fast interrupt makes no memory access. `bk_we` pulses with `bk_sw`/`bk_pc` holding the old status word and program counter, and the new program counter is `fvec_in`.
- R11: In the single `done` cycle, `pc_we`, `isp_we` and `sp_we` are asserted, and `sp_out` equals `isp_out`, the final stack value. `ack` is asserted for interrupts only, with `ack_fast` set for a fast one. `ack_vec` carries the normal vector and is 0 for a fast one.
- R12: `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| nirq_req | input | 1 | normal interrupt request |
| nirq_vec | input | 8 | normal interrupt vector |
| nirq_lvl | input | 4 | normal interrupt level |
| firq_req | input | 1 | fast interrupt request |
| exc_req | input | 1 | exception request |
| exc_vec | input | 9 | exception vector, bit 8 marks a trap |
| sw_in | input | 32 | current status word |
| pc_in | input | 32 | current program counter |
| sp_in | input | 32 | working stack register |
| isp_in | input | 32 | interrupt stack pointer |
| tbase_in | input | 32 | relocatable table base |
| fvec_in | input | 32 | fast interrupt target |
| mem_valid | output | 1 | memory request |
| mem_we | output | 1 | 1 = store |
| mem_addr | output | 32 | memory address |
| mem_wdata | output | 32 | store data |
| mem_ready | input | 1 | memory accepts request |
| mem_rdata | input | 32 | load data, valid with ready |
| busy | output | 1 | sequence in progress |
| usp_we | output | 1 | write user stack pointer |
| usp_out | output | 32 | user stack pointer value |
| sw_we | output | 1 | write status word |
| sw_out | output | 32 | new status word |
| bk_we | output | 1 | write fast backup registers |
| bk_sw | output | 32 | backup status word |
| bk_pc | output | 32 | backup program counter |
| pc_we | output | 1 | write program counter |
| pc_out | output | 32 | new program counter |
| isp_we | output | 1 | write interrupt stack pointer |
| isp_out | output | 32 | new interrupt stack pointer |
| sp_we | output | 1 | write working stack register |
| sp_out | output | 32 | new working stack value |
| done | output | 1 | last cycle of entry |
| ack | output | 1 | interrupt acknowledge |
| ack_fast | output | 1 | acknowledge is for the fast source |
| ack_vec | output | 8 | acknowledged vector |

## Verification
The bench goes after equal levels and level 15, where an off-by-one compare would take a request it must refuse. It also drives simultaneous sources, where a wrong priority would push the wrong frame or acknowledge the wrong source. Trap vectors with bit 8 set must use the relocatable base; a design that got this wrong would jump into the fixed high table. Requests and vectors are changed mid-entry to expose a design that reads live inputs. Random memory stalls expose a design that double-pushes, skips a store, or decrements the stack at the wrong time, any of which shifts the final stack pointer.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SWAP, S_PUSH_SW, S_PUSH_PC, S_FETCH, S_FSAVE, S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        K_NORM, K_FAST, K_EXC
    } entry_kind_t;

    // status word field positions decoded by neighbouring logic
    localparam int SW_LVL_LSB = 0;
    localparam int SW_IEN     = 4;
    localparam int SW_USEL    = 5;
    localparam int SW_PMODE   = 6;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_entry_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             nirq_req,
    input  logic [LVL_W-1:0] nirq_lvl,
    input  logic             firq_req,
    input  logic             exc_req,
    input  logic             ien,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             take,
    output entry_kind_t      kind
);
    localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

    logic norm_ok;
    logic fast_ok;

    always_comb begin
        norm_ok = nirq_req && ien && (cur_lvl < nirq_lvl);
        fast_ok = firq_req && ien && (cur_lvl != LVL_TOP);
        take    = exc_req || fast_ok || norm_ok;
        if (exc_req)      kind = K_EXC;
        else if (fast_ok) kind = K_FAST;
        else              kind = K_NORM;
    end
endmodule

// File: rtl/vec_addr_calc.sv
module vec_addr_calc
    import irq_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              VEC_W    = 8,
    parameter logic [XLEN-1:0] EXC_BASE = 32'hFFFF_FFC0,
    localparam int             EXC_W    = VEC_W + 1
) (
    input  entry_kind_t      kind,
    input  logic [EXC_W-1:0] vec,
    input  logic [XLEN-1:0]  tbase,
    output logic [XLEN-1:0]  addr
);
    logic [XLEN-1:0] low_off;
    logic [XLEN-1:0] full_off;

    always_comb begin
        low_off  = XLEN'(vec[VEC_W-1:0]) << 2;
        full_off = XLEN'(vec) << 2;
        if (kind == K_EXC && !vec[EXC_W-1]) addr = EXC_BASE + full_off;
        else                                addr = tbase + low_off;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8,
    parameter int LVL_W = 4,
    localparam int EXC_W = VEC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nirq_req,
    input  logic [VEC_W-1:0] nirq_vec,
    input  logic [LVL_W-1:0] nirq_lvl,
    input  logic             firq_req,
    input  logic             exc_req,
    input  logic [EXC_W-1:0] exc_vec,
    input  logic [XLEN-1:0]  sw_in,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  sp_in,
    input  logic [XLEN-1:0]  isp_in,
    input  logic [XLEN-1:0]  tbase_in,
    input  logic [XLEN-1:0]  fvec_in,
    output logic             mem_valid,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ready,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             usp_we,
    output logic [XLEN-1:0]  usp_out,
    output logic             sw_we,
    output logic [XLEN-1:0]  sw_out,
    output logic             bk_we,
    output logic [XLEN-1:0]  bk_sw,
    output logic [XLEN-1:0]  bk_pc,
    output logic             pc_we,
    output logic [XLEN-1:0]  pc_out,
    output logic             isp_we,
    output logic [XLEN-1:0]  isp_out,
    output logic             sp_we,
    output logic [XLEN-1:0]  sp_out,
    output logic             done,
    output logic             ack,
    output logic             ack_fast,
    output logic [VEC_W-1:0] ack_vec
);
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    seq_state_t       state, nxt;
    entry_kind_t      kind_r;
    entry_kind_t      arb_kind;
    logic             arb_take;
    logic [EXC_W-1:0] vec_r;
    logic [LVL_W-1:0] lvl_r;
    logic [XLEN-1:0]  sw_r, pc_r, sp_r, isp_r;
    logic             usel_r;
    logic [XLEN-1:0]  vaddr;

    irq_arbiter #(.LVL_W(LVL_W)) u_arb (
        .nirq_req (nirq_req),
        .nirq_lvl (nirq_lvl),
        .firq_req (firq_req),
        .exc_req  (exc_req),
        .ien      (sw_in[SW_IEN]),
        .cur_lvl  (sw_in[SW_LVL_LSB +: LVL_W]),
        .take     (arb_take),
        .kind     (arb_kind)
    );

    vec_addr_calc #(.XLEN(XLEN), .VEC_W(VEC_W)) u_vec (
        .kind  (kind_r),
        .vec   (vec_r),
        .tbase (tbase_in),
        .addr  (vaddr)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (arb_take) nxt = S_SWAP;
            S_SWAP:    nxt = (kind_r == K_FAST) ? S_FSAVE : S_PUSH_SW;
            S_PUSH_SW: if (mem_ready) nxt = S_PUSH_PC;
            S_PUSH_PC: if (mem_ready) nxt = S_FETCH;
            S_FETCH:   if (mem_ready) nxt = S_FINISH;
            S_FSAVE:   nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            kind_r <= K_NORM;
            vec_r  <= '0;
            lvl_r  <= '0;
            sw_r   <= '0;
            pc_r   <= '0;
            sp_r   <= '0;
            isp_r  <= '0;
            usel_r <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: if (arb_take) begin
                    kind_r <= arb_kind;
                    vec_r  <= (arb_kind == K_EXC) ? exc_vec : {1'b0, nirq_vec};
                    lvl_r  <= nirq_lvl;
                    sw_r   <= sw_in;
                    pc_r   <= pc_in;
                    sp_r   <= sp_in;
                    usel_r <= sw_in[SW_USEL];
                    isp_r  <= sw_in[SW_USEL] ? isp_in : sp_in;
                end
                S_SWAP:    if (kind_r != K_FAST) isp_r <= isp_r - WORD;
                S_PUSH_SW: if (mem_ready) isp_r <= isp_r - WORD;
                S_PUSH_PC: ;
                S_FETCH:   if (mem_ready) pc_r <= mem_rdata;
                S_FSAVE:   pc_r <= fvec_in;
                S_FINISH:  ;
                default:   ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        usp_we    = 1'b0;
        usp_out   = sp_r;
        sw_we     = 1'b0;
        sw_out    = sw_r;
        bk_we     = 1'b0;
        bk_sw     = sw_r;
        bk_pc     = pc_r;
        pc_we     = 1'b0;
        pc_out    = pc_r;
        isp_we    = 1'b0;
        isp_out   = isp_r;
        sp_we     = 1'b0;
        sp_out    = isp_r;
        done      = 1'b0;
        ack       = 1'b0;
        ack_fast  = 1'b0;
        ack_vec   = '0;
        busy      = (state != S_IDLE);
        sw_out[SW_IEN]   = 1'b0;
        sw_out[SW_USEL]  = 1'b0;
        sw_out[SW_PMODE] = 1'b0;
        if (kind_r == K_NORM) sw_out[SW_LVL_LSB +: LVL_W] = lvl_r;
        unique case (state)
            S_IDLE: ;
            S_SWAP: begin
                usp_we = usel_r;
                sw_we  = 1'b1;
            end
            S_PUSH_SW: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = isp_r;
                mem_wdata = sw_r;
            end
            S_PUSH_PC: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = isp_r;
                mem_wdata = pc_r;
            end
            S_FETCH: begin
                mem_valid = 1'b1;
                mem_addr  = vaddr;
            end
            S_FSAVE: bk_we = 1'b1;
            S_FINISH: begin
                pc_we    = 1'b1;
                isp_we   = 1'b1;
                sp_we    = 1'b1;
                done     = 1'b1;
                ack      = (kind_r != K_EXC);
                ack_fast = (kind_r == K_FAST);
                ack_vec  = (kind_r == K_NORM) ? vec_r[VEC_W-1:0] : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        nirq_req,
    input logic [3:0]  nirq_lvl,
    input logic        firq_req,
    input logic        exc_req,
    input logic [31:0] sw_in,
    input logic        mem_valid,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ready,
    input logic        busy,
    input logic        sw_we,
    input logic [31:0] sw_out,
    input logic        sp_we,
    input logic        isp_we,
    input logic [31:0] sp_out,
    input logic [31:0] isp_out,
    input logic        done,
    input logic        ack
);
    // R1 R2 R3
    accept_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(exc_req
            || (firq_req && sw_in[4] && sw_in[3:0] != 4'hF)
            || (nirq_req && sw_in[4] && sw_in[3:0] < nirq_lvl)));

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata)));

    // R6
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |-> (!sw_out[4] && !sw_out[5] && !sw_out[6] && busy));

    // R11
    sp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (isp_we && done && sp_out == isp_out));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    ack_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> done);
endmodule

bind irq_entry_seq irq_entry_chk chk (
    .clk(clk), .rst_n(rst_n), .nirq_req(nirq_req), .nirq_lvl(nirq_lvl),
    .firq_req(firq_req), .exc_req(exc_req), .sw_in(sw_in),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .busy(busy),
    .sw_we(sw_we), .sw_out(sw_out), .sp_we(sp_we), .isp_we(isp_we),
    .sp_out(sp_out), .isp_out(isp_out), .done(done), .ack(ack)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        nirq_req = 0, firq_req = 0, exc_req = 0;
    logic [7:0]  nirq_vec = 0;
    logic [3:0]  nirq_lvl = 0;
    logic [8:0]  exc_vec = 0;
    logic [31:0] sw_in = 0, pc_in = 0, sp_in = 0, isp_in = 0, tbase_in = 0, fvec_in = 0;
    logic        mem_valid, mem_we, mem_ready = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, usp_we, sw_we, bk_we, pc_we, isp_we, sp_we, done, ack, ack_fast;
    logic [31:0] usp_out, sw_out, bk_sw, bk_pc, pc_out, isp_out, sp_out;
    logic [7:0]  ack_vec;

    assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

    irq_entry_seq uut (.*);

    int n_tests = 0, n_fail = 0;
    logic [31:0] wa[4], wd[4], fa;
    int nw, nf, n_usp, n_sw, n_bk;
    logic [31:0] usp_v, sw_v, bksw_v, bkpc_v, pc_v, isp_v, sp_v;
    logic ack_v, ackf_v, done_seen;
    logic [7:0] ackvec_v;

    always @(negedge clk) begin
        if (mem_valid) begin
            mem_ready = ($urandom_range(0, 2) != 0);
            if (mem_ready) begin
                if (mem_we && nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
                else if (!mem_we) begin fa = mem_addr; nf++; end
            end
        end else mem_ready = 1'b0;
        if (usp_we) begin usp_v = usp_out; n_usp++; end
        if (sw_we)  begin sw_v = sw_out; n_sw++; end
        if (bk_we)  begin bksw_v = bk_sw; bkpc_v = bk_pc; n_bk++; end
        if (done) begin
            done_seen = 1'b1;
            pc_v = pc_we ? pc_out : 32'hDEAD;
            isp_v = isp_we ? isp_out : 32'hDEAD;
            sp_v = sp_we ? sp_out : 32'hDEAD;
            ack_v = ack; ackf_v = ack_fast; ackvec_v = ack_vec;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sw(input logic [31:0] sw, input int kind, input logic [3:0] lvl);
        logic [31:0] r = sw;
        r[4] = 0; r[5] = 0; r[6] = 0;
        if (kind == 0) r[3:0] = lvl;
        return r;
    endfunction

    function automatic logic [31:0] exp_vaddr(input int kind, input logic [8:0] v, input logic [31:0] tb);
        if (kind == 2 && !v[8]) return 32'hFFFF_FFC0 + ({23'd0, v} << 2);
        return tb + ({24'd0, v[7:0]} << 2);
    endfunction

    // kind: 0 normal, 1 fast, 2 exception (the expected winner)
    task automatic run_entry(input int kind, input bit mutate);
        logic [31:0] base, o_sw, o_pc, o_sp, o_tb, o_fv;
        logic [7:0] o_nv; logic [3:0] o_nl; logic [8:0] o_ev;
        bit ok = 0;
        @(negedge clk);
        nw = 0; nf = 0; n_usp = 0; n_sw = 0; n_bk = 0; done_seen = 0;
        o_sw = sw_in; o_pc = pc_in; o_sp = sp_in; o_tb = tbase_in; o_fv = fvec_in;
        o_nv = nirq_vec; o_nl = nirq_lvl; o_ev = exc_vec;
        base = o_sw[5] ? isp_in : sp_in;
        @(negedge clk); #1;
        check("R3 busy after accept", {31'd0, busy}, 32'd1);
        if (mutate) begin
            nirq_vec = ~nirq_vec; nirq_lvl = 4'hF; exc_vec = exc_vec ^ 9'h0AA;
            sw_in = ~sw_in; pc_in = ~pc_in; sp_in = sp_in + 32'h100;
        end
        for (int i = 0; i < 300; i++) begin
            if (done_seen) begin ok = 1; break; end
            @(negedge clk); #1;
        end
        nirq_req = 0; firq_req = 0; exc_req = 0;
        check("watchdog done", {31'd0, ok}, 32'd1);
        check("R5 usp writes", n_usp, o_sw[5] ? 1 : 0);
        if (o_sw[5]) check("R5 usp value", usp_v, o_sp);
        check("R6 status writes", n_sw, 1);
        check("R6 status value", sw_v, exp_sw(o_sw, kind, o_nl));
        if (kind == 1) begin
            check("R10 no stores", nw + nf, 0);
            check("R10 backup writes", n_bk, 1);
            check("R10 backup sw", bksw_v, o_sw);
            check("R10 backup pc", bkpc_v, o_pc);
            check("R10 new pc", pc_v, o_fv);
            check("R11 final isp", isp_v, base);
            check("R11 final sp", sp_v, base);
        end else begin
            check("R12 store count", nw, 2);
            check("R7 first store addr", wa[0], base - 4);
            check("R7 first store data", wd[0], o_sw);
            check("R7 second store addr", wa[1], base - 8);
            check("R7 second store data", wd[1], o_pc);
            check("R12 fetch count", nf, 1);
            check(kind == 0 ? "R8 fetch addr" : "R9 fetch addr", fa, exp_vaddr(kind, kind == 2 ? o_ev : {1'b0, o_nv}, o_tb));
            check("R8 new pc", pc_v, exp_vaddr(kind, kind == 2 ? o_ev : {1'b0, o_nv}, o_tb) ^ 32'hA5A5_0000);
            check("R11 final isp", isp_v, base - 8);
            check("R11 final sp", sp_v, base - 8);
        end
        check("R11 ack", {31'd0, ack_v}, kind != 2 ? 1 : 0);
        check("R11 ack fast", {31'd0, ackf_v}, kind == 1 ? 1 : 0);
        check("R11 ack vec", {24'd0, ackvec_v}, kind == 0 ? {24'd0, o_nv} : 0);
        if (mutate) check("R4 latched vector", {24'd0, ackvec_v}, kind == 0 ? {24'd0, o_nv} : 0);
        @(negedge clk); #1;
    endtask

    task automatic expect_reject(input string req);
        @(negedge clk);
        repeat (3) @(negedge clk);
        #1 check(req, {31'd0, busy}, 32'd0);
        nirq_req = 0; firq_req = 0; exc_req = 0;
        @(negedge clk);
    endtask

    task automatic set_ctx();
        sw_in = $urandom; pc_in = $urandom & ~32'h3; sp_in = ($urandom | 32'h100) & ~32'h3;
        isp_in = ($urandom | 32'h100) & ~32'h3; tbase_in = $urandom & ~32'h3FF; fvec_in = $urandom;
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        #1 check("R11 reset busy", {31'd0, busy}, 0);
        check("R12 reset valid", {31'd0, mem_valid}, 0);
        rst_n = 1'b1;

        // directed rejects
        set_ctx(); sw_in[4] = 1; sw_in[3:0] = 4'd6; nirq_lvl = 4'd6; nirq_req = 1;
        expect_reject("R1 equal level rejected");
        set_ctx(); sw_in[4] = 0; sw_in[3:0] = 4'd0; nirq_lvl = 4'd9; nirq_req = 1;
        expect_reject("R1 disabled rejected");
        set_ctx(); sw_in[4] = 1; sw_in[3:0] = 4'hF; firq_req = 1;
        expect_reject("R2 fast at level 15 rejected");

        // directed accepts
        set_ctx(); sw_in[4] = 1; sw_in[5] = 1; sw_in[3:0] = 4'd14; firq_req = 1;
        run_entry(1, 0);
        set_ctx(); sw_in[4] = 1; sw_in[3:0] = 4'd5; nirq_lvl = 4'd6; nirq_vec = 8'h3C; nirq_req = 1;
        run_entry(0, 1);
        set_ctx(); sw_in[4] = 1; sw_in[3:0] = 4'd1; nirq_lvl = 4'd7; nirq_req = 1; firq_req = 1;
        run_entry(1, 0);
        set_ctx(); sw_in[4] = 0; sw_in[3:0] = 4'hF; exc_vec = 9'h1FF; exc_req = 1; firq_req = 1;
        run_entry(2, 1);
        set_ctx(); sw_in[5] = 1; exc_vec = 9'h00F; exc_req = 1;
        run_entry(2, 0);

        // constrained random
        for (int it = 0; it < 60; it++) begin
            int k;
            set_ctx();
            k = $urandom_range(0, 2);
            sw_in[4] = 1;
            if (k == 0) begin
                sw_in[3:0] = $urandom_range(0, 14);
                nirq_lvl = sw_in[3:0] + 4'($urandom_range(1, 15 - sw_in[3:0]));
                nirq_vec = $urandom; nirq_req = 1;
            end else if (k == 1) begin
                sw_in[3:0] = $urandom_range(0, 14); firq_req = 1;
                nirq_req = $urandom_range(0, 1); nirq_lvl = 4'hF;
            end else begin
                exc_vec = $urandom_range(0, 1) ? {1'b1, 8'($urandom)} : 9'($urandom_range(0, 15));
                exc_req = 1; firq_req = $urandom_range(0, 1);
                sw_in[4] = $urandom_range(0, 1);
            end
            run_entry(k, $urandom_range(0, 1) == 1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule